// File: doc/BRIEF.md
# Command-Framed Serial Slave Port

This block is the serial slave side of a data converter's register bank. A host talks to it over a clock line, one input line and one output line, with an optional active-low select. Every access is two-phase: the host first shifts in one 8-bit command byte. That byte picks one of eight registers and the direction of the access. The port then moves 8 or 24 data bits into or out of that register and goes back to waiting for the next command byte.

The serial clock, data and select pins are sampled by the system clock and edge-detected, so the whole port runs in one clock domain. Framing depends only on counting serial clock edges. A select line tied low for good therefore works. A strap pin picks the idle level of the serial clock. Writes reach the bank as a one-cycle enable with the assembled word. Reads take a snapshot of the bank word the moment the command byte completes. A data-ready flag, set by the converter and cleared by reading the result register, is driven on an active-low pin and also appears in the status byte.

Top module: `ssp_cmd_port`

## Requirements
- R1: With `cs_n` held low throughout, transactions are framed only by counting active serial clock edges: 8 for a command byte, then the data phase it announces.
- R2: Command byte, first bit sent = bit 7: bit 7 must be 0, bits 6:4 select the register, bit 3 is 1 for read and 0 for write, bits 2:0 are ignored. A byte with bit 7 = 1 is a no-op, so a stream of ones leaves the port waiting for a command.
- R3: The data phase follows the command byte with no gap needed: command and 8 data bits may be sent as one continuous 16-clock burst.
- R4: A write pulses exactly one bit `wr_en[sel]` for one cycle, with `wr_data` holding the received word. For an 8-bit register the byte sits in bits 7:0 and the upper bits are 0. Data is sent MSB first.
- R5: Registers whose bit is set in `WIDE_MASK` (default registers 5 and 6) take 24 data bits. One 24-clock burst and three 8-clock bursts separated by pauses give the same result. No enable fires before the last bit.
- R6: Half duplex: `sdo_oe` is low except during a read data phase. During a read, `sdi` is ignored and no write enable fires.
- R7: With `pol` = 0, SCLK idles low and data is sampled on the rising edge. With `pol` = 1, SCLK idles high and data is sampled on the falling edge.
- R8: A read sends the bank word as it was when the command byte completed, MSB first, with `sdo` changing on the edge returning to idle. An 8-bit register sends `rd_data[7:0]`. Register 0 reads as status byte {ready, 7'b0}.
- R9: A `new_result` pulse drives `rdy_n` low on the next cycle. `rdy_n` returns high only after the last bit of a read of register 5 (the result register). A set in the same cycle as a clear wins.
- R10: Raising `cs_n` aborts any partial transfer: no register is written, `sdo_oe` drops, and the next bits are taken as a new command byte.
- R11: A write command to register 0 has no data phase. The next 8 bits are taken as a new command byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sclk | input | 1 | Serial clock from host |
| sdi | input | 1 | Serial data from host |
| cs_n | input | 1 | Active-low select, may be tied low |
| pol | input | 1 | Serial clock idle-level strap |
| new_result | input | 1 | Converter pulse: result register loaded |
| rd_data | input | DW | Bank word of the register on `rd_sel` |
| sdo | output | 1 | Serial data to host |
| sdo_oe | output | 1 | Output enable for `sdo` |
| rdy_n | output | 1 | Active-low data-ready |
| rd_sel | output | 3 | Register addressed for read |
| wr_en | output | 8 | One-hot write enables |
| wr_data | output | DW | Word to write |

## Verification
The main function is tried as continuous 16- and 24-clock bursts and as byte-wise bursts with idle gaps. Matching results show that framing uses edge counts and not timing. Streams of all-ones bytes, a command-only write to register 0, and transfers cut short by the select line each check that the next byte is still taken as a command. Reads are run with toggling input data, and the result register is changed part-way through a read, so both half-duplex steering and snapshot capture are tested. The strap is flipped and a write and a read are repeated, to show that the sampling and launching edges follow it.

// File: rtl/ssp_pkg.sv
package ssp_pkg;
  localparam int CMD_W  = 8;
  localparam int SEL_W  = 3;
  localparam int NREG   = 1 << SEL_W;
  localparam int NARROW = 8;

  typedef enum logic [1:0] {
    ST_CMD = 2'd0,
    ST_ARM = 2'd1,
    ST_WR  = 2'd2,
    ST_RD  = 2'd3
  } ssp_state_e;
endpackage

// File: rtl/ssp_sync_edge.sv
module ssp_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pol,
  input  logic sclk,
  input  logic sdi,
  input  logic cs_n,
  output logic act_edge,
  output logic ret_edge,
  output logic din,
  output logic selected
);
  localparam int W = 3;

  logic [W-1:0] raw;
  logic [W-1:0] rst_val;
  logic [W-1:0] chain [STAGES];
  logic         lvl_prev;
  logic         lvl_now;

  assign raw     = {cs_n, sdi, sclk};
  assign rst_val = {1'b1, 1'b0, pol};

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) chain[g] <= rst_val;
        else     chain[g] <= raw;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) chain[g] <= rst_val;
        else     chain[g] <= chain[g-1];
      end
    end
  end

  // normalised level: 1 means away from idle
  assign lvl_now = chain[STAGES-1][0] ^ pol;

  always_ff @(posedge clk) begin
    if (rst) lvl_prev <= 1'b0;
    else     lvl_prev <= lvl_now;
  end

  assign act_edge = lvl_now & ~lvl_prev;
  assign ret_edge = ~lvl_now & lvl_prev;
  assign din      = chain[STAGES-1][1];
  assign selected = ~chain[STAGES-1][2];
endmodule

// File: rtl/ssp_ready_flag.sv
module ssp_ready_flag (
  input  logic clk,
  input  logic rst,
  input  logic set_p,
  input  logic clr_p,
  output logic rdy,
  output logic rdy_n
);
  logic nxt;

  always_comb begin
    nxt = rdy;
    if (clr_p) nxt = 1'b0;
    if (set_p) nxt = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdy   <= 1'b0;
      rdy_n <= 1'b1;
    end else begin
      rdy   <= nxt;
      rdy_n <= ~nxt;
    end
  end
endmodule

// File: rtl/ssp_frame_ctrl.sv
module ssp_frame_ctrl
  import ssp_pkg::*;
#(
  parameter int               DW        = 24,
  parameter logic [NREG-1:0]  WIDE_MASK = 8'b0110_0000,
  parameter int               DATA_REG  = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             act_edge,
  input  logic             ret_edge,
  input  logic             din,
  input  logic             selected,
  input  logic             rdy,
  input  logic [DW-1:0]    rd_data,
  output logic [SEL_W-1:0] rd_sel,
  output logic             sdo,
  output logic             sdo_oe,
  output logic [NREG-1:0]  wr_en,
  output logic [DW-1:0]    wr_data,
  output logic             data_read_done
);
  localparam int CNTW = $clog2(DW + 1);
  localparam logic [CNTW-1:0] LEN_WIDE   = CNTW'(DW);
  localparam logic [CNTW-1:0] LEN_NARROW = CNTW'(NARROW);
  localparam logic [CNTW-1:0] CMD_LAST   = CNTW'(CMD_W - 1);

  ssp_state_e       state;
  logic [CNTW-1:0]  cnt;
  logic [CNTW-1:0]  len_q;
  logic [DW-1:0]    shreg;
  logic [SEL_W-1:0] sel_q;
  logic [CMD_W-1:0] cmd_byte;
  logic [SEL_W-1:0] cmd_sel;
  logic             cmd_rd;
  logic             last_bit;

  assign cmd_byte = {shreg[CMD_W-2:0], din};
  assign cmd_sel  = cmd_byte[6:4];
  assign cmd_rd   = cmd_byte[3];
  assign last_bit = (cnt == len_q - 1'b1);

  always_ff @(posedge clk) begin
    if (rst || !selected) begin
      state          <= ST_CMD;
      cnt            <= '0;
      len_q          <= LEN_NARROW;
      shreg          <= '0;
      sel_q          <= '0;
      rd_sel         <= '0;
      sdo            <= 1'b0;
      sdo_oe         <= 1'b0;
      wr_en          <= '0;
      wr_data        <= '0;
      data_read_done <= 1'b0;
    end else begin
      wr_en          <= '0;
      data_read_done <= 1'b0;
      unique case (state)
        ST_CMD: begin
          if (act_edge) begin
            shreg <= {shreg[DW-2:0], din};
            cnt   <= cnt + 1'b1;
            if (cnt == CMD_LAST) begin
              cnt <= '0;
              if (!cmd_byte[7]) begin
                sel_q <= cmd_sel;
                len_q <= WIDE_MASK[cmd_sel] ? LEN_WIDE : LEN_NARROW;
                if (cmd_rd) begin
                  rd_sel <= cmd_sel;
                  state  <= ST_ARM;
                end else if (cmd_sel != '0) begin
                  state <= ST_WR;
                end
              end
            end
          end
        end
        ST_ARM: begin
          if (sel_q == '0)
            shreg <= {rdy, {(DW-1){1'b0}}};
          else if (WIDE_MASK[sel_q])
            shreg <= rd_data;
          else
            shreg <= {rd_data[NARROW-1:0], {(DW-NARROW){1'b0}}};
          sdo_oe <= 1'b1;
          state  <= ST_RD;
        end
        ST_RD: begin
          if (ret_edge) begin
            sdo   <= shreg[DW-1];
            shreg <= {shreg[DW-2:0], 1'b0};
          end
          if (act_edge) begin
            cnt <= cnt + 1'b1;
            if (last_bit) begin
              cnt            <= '0;
              sdo_oe         <= 1'b0;
              state          <= ST_CMD;
              data_read_done <= (sel_q == SEL_W'(DATA_REG));
            end
          end
        end
        ST_WR: begin
          if (act_edge) begin
            shreg <= {shreg[DW-2:0], din};
            cnt   <= cnt + 1'b1;
            if (last_bit) begin
              cnt          <= '0;
              state        <= ST_CMD;
              wr_en[sel_q] <= 1'b1;
              if (len_q == LEN_NARROW)
                wr_data <= {{(DW-NARROW){1'b0}}, shreg[NARROW-2:0], din};
              else
                wr_data <= {shreg[DW-2:0], din};
            end
          end
        end
        default: state <= ST_CMD;
      endcase
    end
  end
endmodule

// File: rtl/ssp_cmd_port.sv
module ssp_cmd_port
  import ssp_pkg::*;
#(
  parameter int               DW          = 24,
  parameter logic [NREG-1:0]  WIDE_MASK   = 8'b0110_0000,
  parameter int               DATA_REG    = 5,
  parameter int               SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sclk,
  input  logic             sdi,
  input  logic             cs_n,
  input  logic             pol,
  input  logic             new_result,
  input  logic [DW-1:0]    rd_data,
  output logic             sdo,
  output logic             sdo_oe,
  output logic             rdy_n,
  output logic [SEL_W-1:0] rd_sel,
  output logic [NREG-1:0]  wr_en,
  output logic [DW-1:0]    wr_data
);
  logic act_edge, ret_edge, din, selected;
  logic rdy, data_read_done;

  ssp_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst      (rst),
    .pol      (pol),
    .sclk     (sclk),
    .sdi      (sdi),
    .cs_n     (cs_n),
    .act_edge (act_edge),
    .ret_edge (ret_edge),
    .din      (din),
    .selected (selected)
  );

  ssp_frame_ctrl #(
    .DW        (DW),
    .WIDE_MASK (WIDE_MASK),
    .DATA_REG  (DATA_REG)
  ) u_frame (
    .clk            (clk),
    .rst            (rst),
    .act_edge       (act_edge),
    .ret_edge       (ret_edge),
    .din            (din),
    .selected       (selected),
    .rdy            (rdy),
    .rd_data        (rd_data),
    .rd_sel         (rd_sel),
    .sdo            (sdo),
    .sdo_oe         (sdo_oe),
    .wr_en          (wr_en),
    .wr_data        (wr_data),
    .data_read_done (data_read_done)
  );

  ssp_ready_flag u_rdy (
    .clk   (clk),
    .rst   (rst),
    .set_p (new_result),
    .clr_p (data_read_done),
    .rdy   (rdy),
    .rdy_n (rdy_n)
  );
endmodule

// File: rtl/ssp_cmd_port_chk.sv
module ssp_cmd_port_chk #(
  parameter int DW = 24
) (
  input logic          clk,
  input logic          rst,
  input logic          cs_n,
  input logic          new_result,
  input logic          sdo_oe,
  input logic          rdy_n,
  input logic [7:0]    wr_en,
  input logic [DW-1:0] wr_data
);
  int unsigned since_rst;

  always_ff @(posedge clk) begin
    if (rst) since_rst <= 0;
    else if (since_rst < 8) since_rst <= since_rst + 1;
  end

  p_one_enable_r4: assert property (@(posedge clk) disable iff (rst)
    $onehot0(wr_en));

  p_no_write_while_driving_r6: assert property (@(posedge clk) disable iff (rst)
    (wr_en != '0) |-> !sdo_oe);

  p_ready_sets_r9: assert property (@(posedge clk) disable iff (rst)
    new_result |=> !rdy_n);

  p_ready_holds_clear_r9: assert property (@(posedge clk) disable iff (rst)
    (since_rst > 1 && rdy_n && !new_result) |=> rdy_n);

  p_deselect_quiet_r10: assert property (@(posedge clk) disable iff (rst)
    (since_rst > 4 && cs_n && $past(cs_n) && $past(cs_n, 2) && $past(cs_n, 3))
      |-> (!sdo_oe && wr_en == '0));
endmodule

bind ssp_cmd_port ssp_cmd_port_chk #(.DW(DW)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .cs_n       (cs_n),
  .new_result (new_result),
  .sdo_oe     (sdo_oe),
  .rdy_n      (rdy_n),
  .wr_en      (wr_en),
  .wr_data    (wr_data)
);

// File: tb/test_ssp_cmd_port.sv
module test_ssp_cmd_port;
  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 8;
  localparam int DW         = 24;
  localparam int WATCHDOG   = 150000;

  logic          clk = 1'b0;
  logic          rst, sclk, sdi, cs_n, pol, new_result;
  logic [DW-1:0] rd_data;
  logic          sdo, sdo_oe, rdy_n;
  logic [2:0]    rd_sel;
  logic [7:0]    wr_en;
  logic [DW-1:0] wr_data;

  int n_checks = 0;
  int n_fails  = 0;
  int wr_count = 0;
  int last_idx = -1;
  logic [DW-1:0] last_data;
  logic [DW-1:0] bank [8];
  logic          oe_seen;

  always #(CLK_PERIOD/2) clk = ~clk;

  ssp_cmd_port i_ssp_cmd_port (
    .clk(clk), .rst(rst), .sclk(sclk), .sdi(sdi), .cs_n(cs_n), .pol(pol),
    .new_result(new_result), .rd_data(rd_data), .sdo(sdo), .sdo_oe(sdo_oe),
    .rdy_n(rdy_n), .rd_sel(rd_sel), .wr_en(wr_en), .wr_data(wr_data)
  );

  // behavioural register bank
  assign rd_data = bank[rd_sel];

  always @(posedge clk) begin
    for (int i = 0; i < 8; i++) begin
      if (wr_en[i]) begin
        bank[i]   <= wr_data;
        wr_count  <= wr_count + 1;
        last_idx  <= i;
        last_data <= wr_data;
      end
    end
  end

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    n_checks++;
    n_fails++;
    $display("FAIL watchdog: actual=%0d cycles expected<%0d", WATCHDOG, WATCHDOG);
    finish_run();
  end

  task automatic check(input logic ok, input string req, input logic [DW-1:0] act,
                       input logic [DW-1:0] exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // one serial bit: set data in idle half, sample sdo, active edge, return edge
  task automatic bit_clock(input logic b, output logic o);
    sdi = b;
    repeat (HALF) @(negedge clk);
    o = sdo;
    if (sdo_oe) oe_seen = 1'b1;
    sclk = ~pol;
    repeat (HALF) @(negedge clk);
    sclk = pol;
  endtask

  task automatic send_byte(input logic [7:0] b, output logic [7:0] got);
    for (int i = 7; i >= 0; i--) begin
      logic o;
      bit_clock(b[i], o);
      got[i] = o;
    end
  endtask

  task automatic do_reset(input logic p);
    rst = 1'b1; pol = p; sclk = p; sdi = 1'b0; cs_n = 1'b0; new_result = 1'b0;
    idle(6);
    rst = 1'b0;
    idle(6);
  endtask

  logic [7:0]  g0, g1, g2;
  int          wc;

  initial begin
    for (int i = 0; i < 8; i++) bank[i] = 24'h0F1E2D ^ (24'(i) * 24'h111111);
    do_reset(1'b0);

    check(rdy_n == 1'b1, "R9 reset rdy_n", 24'(rdy_n), 24'h1);
    check(sdo_oe == 1'b0, "R6 reset sdo_oe", 24'(sdo_oe), 24'h0);
    check(wr_en == 8'h0, "R4 reset wr_en", 24'(wr_en), 24'h0);

    // R1 R3 R4: continuous 16-clock write of reg 2, command 0x20
    wc = wr_count; oe_seen = 1'b0;
    send_byte(8'h20, g0); send_byte(8'hA5, g0);
    idle(10);
    check(wr_count == wc + 1, "R3 one write", 24'(wr_count - wc), 24'h1);
    check(last_idx == 2 && last_data == 24'h0000A5, "R4 write data", last_data, 24'h0000A5);
    check(!oe_seen, "R6 sdo_oe stays low during write", 24'(oe_seen), 24'h0);

    // R5: reg 6 in three bursts with pauses
    wc = wr_count;
    send_byte(8'h60, g0); idle(40);
    send_byte(8'h12, g0); idle(40);
    send_byte(8'h34, g0); idle(40);
    check(wr_count == wc, "R5 no commit before last bit", 24'(wr_count - wc), 24'h0);
    send_byte(8'h56, g0); idle(10);
    check(wr_count == wc + 1 && last_idx == 6, "R5 single commit", 24'(last_idx), 24'h6);
    check(last_data == 24'h123456, "R5 burst-wise 24-bit word", last_data, 24'h123456);

    // R8 R6: reads with toggling sdi
    wc = wr_count;
    send_byte(8'h28, g0); send_byte(8'h5A, g1);
    idle(10);
    check(g1 == 8'hA5, "R8 read 8-bit reg 2", 24'(g1), 24'hA5);
    send_byte(8'h68, g0);
    send_byte(8'hFF, g0); send_byte(8'h00, g1); send_byte(8'hC3, g2);
    idle(10);
    check({g0, g1, g2} == 24'h123456, "R8 read 24-bit reg 6", {g0, g1, g2}, 24'h123456);
    check(wr_count == wc, "R6 sdi ignored during reads", 24'(wr_count - wc), 24'h0);

    // R9: data ready set, status, snapshot, clear
    @(negedge clk); new_result = 1'b1; @(negedge clk); new_result = 1'b0;
    idle(2);
    check(rdy_n == 1'b0, "R9 rdy_n low after new result", 24'(rdy_n), 24'h0);
    send_byte(8'h08, g0); send_byte(8'h00, g1);
    idle(10);
    check(g1 == 8'h80, "R8 status byte shows ready", 24'(g1), 24'h80);
    bank[5] = 24'hABCDEF;
    send_byte(8'h58, g0);
    send_byte(8'h00, g0);
    bank[5] = 24'h111111;
    send_byte(8'h00, g1);
    check(rdy_n == 1'b0, "R9 not cleared before last bit", 24'(rdy_n), 24'h0);
    send_byte(8'h00, g2);
    idle(10);
    check({g0, g1, g2} == 24'hABCDEF, "R8 snapshot not torn", {g0, g1, g2}, 24'hABCDEF);
    check(rdy_n == 1'b1, "R9 cleared by result read", 24'(rdy_n), 24'h1);

    // R2: ones stream is a no-op
    wc = wr_count;
    send_byte(8'hFF, g0); send_byte(8'hFF, g0);
    send_byte(8'h20, g0); send_byte(8'h3C, g0);
    idle(10);
    check(wr_count == wc + 1 && last_idx == 2 && last_data == 24'h3C,
          "R2 ones ignored, next command honoured", last_data, 24'h3C);

    // R11: write command to reg 0 has no data phase
    wc = wr_count;
    send_byte(8'h00, g0); send_byte(8'h10, g0); send_byte(8'h77, g0);
    idle(10);
    check(wr_count == wc + 1 && last_idx == 1 && last_data == 24'h77,
          "R11 reg 0 write then new command", last_data, 24'h77);

    // R10: abort a write and a read with cs_n
    wc = wr_count;
    send_byte(8'h60, g0);
    for (int i = 0; i < 12; i++) begin logic o; bit_clock(i[0], o); end
    cs_n = 1'b1; idle(10); cs_n = 1'b0; idle(10);
    send_byte(8'h30, g0); send_byte(8'h99, g0);
    idle(10);
    check(wr_count == wc + 1 && last_idx == 3 && last_data == 24'h99,
          "R10 aborted write dropped", last_data, 24'h99);
    send_byte(8'h28, g0);
    for (int i = 0; i < 4; i++) begin logic o; bit_clock(1'b0, o); end
    cs_n = 1'b1; idle(10);
    check(sdo_oe == 1'b0, "R10 sdo_oe drops on deselect", 24'(sdo_oe), 24'h0);
    cs_n = 1'b0; idle(10);

    // R7: strap high, SCLK idles high
    do_reset(1'b1);
    wc = wr_count;
    send_byte(8'h40, g0); send_byte(8'h5A, g0);
    idle(10);
    check(wr_count == wc + 1 && last_idx == 4 && last_data == 24'h5A,
          "R7 write with pol high", last_data, 24'h5A);
    send_byte(8'h48, g0); send_byte(8'h00, g1);
    idle(10);
    check(g1 == 8'h5A, "R7 read with pol high", 24'(g1), 24'h5A);

    finish_run();
  end
endmodule